// File: doc/BRIEF.md
# Console CPU Bus Address Decoder

This block sits between an 8-bit CPU with a 16-bit address bus and the devices behind it. Each cycle it classifies one transaction from the address and the read and write strobes. It then drives one chip select and a masked local offset to the selected device. The devices are a 2 KB work RAM, an eight-register video unit, an audio unit and a pair of controller ports. A write to the DMA port reaches no device. That write instead latches the data byte as a page number, and the following cycle carries a single-cycle start pulse.

An external cartridge port sees every transaction before the internal map is consulted. When it raises its claim line during a strobe, every internal select stays low and no DMA request is made. A read then returns the cartridge's byte. Read data from the selected source passes through a registered multiplexer, so the CPU gets its byte on the edge after the read strobe. The registered value holds until the next read.

A small phase machine tracks the kind of transaction on the previous edge. Its states are ST_IDLE (no strobe), ST_READ (a read was taken), ST_WRITE (a write went to a device, to the cartridge or to nowhere) and ST_DMA (an unclaimed write hit the DMA port). On every clock it moves to ST_DMA for an unclaimed DMA-port write. Failing that, it moves to ST_WRITE for any other write and to ST_READ for a read. With no strobe it moves to ST_IDLE. The start pulse is high exactly while the machine is in ST_DMA.

Top module: `cpu_bus_decoder`

## Requirements
- R1: When cart_claim is high during a read or write strobe, ram_sel, vid_sel, snd_sel and pad_sel stay low and no DMA pulse follows. A claimed read returns cart_rdata on cpu_rdata one cycle later.
- R2: An unclaimed access in 0x0000..0x1FFF raises ram_sel with ram_off = address bits [10:0], so data written at one address reads back at every address that differs only in bits [12:11].
- R3: An unclaimed access in 0x2000..0x3FFF raises vid_sel with vid_off = address bits [2:0], so the eight registers repeat every 8 bytes.
- R4: snd_sel is raised by an unclaimed read of 0x4015. It is also raised by an unclaimed write to 0x4000..0x4013, 0x4015 or 0x4017. snd_off = address bits [4:0].
- R5: An unclaimed write to 0x4014 raises no select. On the next cycle dma_start is high, and dma_page holds that write's data byte until the next such write. dma_start is low in every cycle that does not follow such a write.
- R6: An unclaimed read of 0x4016 or 0x4017 raises pad_sel with pad_port = address bit 0 (0 for 0x4016, 1 for 0x4017). An unclaimed write to 0x4016 raises pad_sel with pad_port 0.
- R7: An unclaimed read of an address that maps to no device raises no select and returns 0x00 on cpu_rdata one cycle later.
- R8: At most one of ram_sel, vid_sel, snd_sel and pad_sel is high in any cycle, and none is high without a strobe.
- R9: cpu_rdata takes the selected source's byte on the clock edge that samples the read strobe. It keeps its value through idle and write cycles.
- R10: When cpu_rd and cpu_wr are both high, the transaction is treated as a write alone and cpu_rdata does not change.
- R11: During reset, cpu_rdata is 0x00, dma_start is low and dma_page is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Registered read data |
| cart_claim | input | 1 | Cartridge claims the current transaction |
| cart_rdata | input | 8 | Cartridge read data |
| ram_sel | output | 1 | Work RAM select |
| ram_off | output | 11 | Work RAM offset |
| ram_rdata | input | 8 | Work RAM read data |
| vid_sel | output | 1 | Video unit select |
| vid_off | output | 3 | Video register index |
| vid_rdata | input | 8 | Video unit read data |
| snd_sel | output | 1 | Audio unit select |
| snd_off | output | 5 | Audio register index |
| snd_rdata | input | 8 | Audio unit read data |
| pad_sel | output | 1 | Controller port select |
| pad_port | output | 1 | Controller port number |
| pad_rdata | input | 8 | Controller read data |
| dma_start | output | 1 | One-cycle DMA start request |
| dma_page | output | 8 | Latched DMA page |

## Verification
Selects, offsets and pad_port come from combinational logic and are due in the same cycle as the address and strobes. The bench drives inputs on the falling edge and compares these outputs 1 ns later. cpu_rdata, dma_start and dma_page each pass through one register, so they are due on the next rising edge. The bench compares them at the falling edge that follows, against the expectation it computed when it drove the stimulus. Both sweeps of the full 64 K space, one of reads and one of writes, use this same two-phase comparison in every cycle.

// File: rtl/cpu_bus_pkg.sv
package cpu_bus_pkg;

    // Fixed points of the memory map, in CPU address space
    localparam logic [15:0] MAP_RAM_HI   = 16'h1FFF;
    localparam logic [15:0] MAP_VID_HI   = 16'h3FFF;
    localparam logic [15:0] MAP_SND_LO   = 16'h4000;
    localparam logic [15:0] MAP_SND_WHI  = 16'h4013;
    localparam logic [15:0] MAP_DMA      = 16'h4014;
    localparam logic [15:0] MAP_SND_STAT = 16'h4015;
    localparam logic [15:0] MAP_PAD0     = 16'h4016;
    localparam logic [15:0] MAP_PAD1     = 16'h4017;

    // Destination of one bus transaction
    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_RAM,
        TGT_VID,
        TGT_SND,
        TGT_PAD,
        TGT_DMA,
        TGT_CART
    } tgt_e;

    // Kind of transaction taken on the previous edge
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_DMA
    } phase_e;

    // Classified transaction
    typedef struct packed {
        tgt_e tgt;
        logic rd;
        logic wr;
    } xact_t;

endpackage

// File: rtl/busdec_classify.sv
module busdec_classify
    import cpu_bus_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic              claim,
    output xact_t             xact
);

    localparam logic [ADDR_W-1:0] A_RAM_HI   = ADDR_W'(MAP_RAM_HI);
    localparam logic [ADDR_W-1:0] A_VID_HI   = ADDR_W'(MAP_VID_HI);
    localparam logic [ADDR_W-1:0] A_SND_LO   = ADDR_W'(MAP_SND_LO);
    localparam logic [ADDR_W-1:0] A_SND_WHI  = ADDR_W'(MAP_SND_WHI);
    localparam logic [ADDR_W-1:0] A_DMA      = ADDR_W'(MAP_DMA);
    localparam logic [ADDR_W-1:0] A_SND_STAT = ADDR_W'(MAP_SND_STAT);
    localparam logic [ADDR_W-1:0] A_PAD0     = ADDR_W'(MAP_PAD0);
    localparam logic [ADDR_W-1:0] A_PAD1     = ADDR_W'(MAP_PAD1);

    tgt_e wr_tgt;
    tgt_e rd_tgt;

    // Write-side map of the I/O window above the video mirror
    always_comb begin
        if (addr >= A_SND_LO && addr <= A_SND_WHI) begin
            wr_tgt = TGT_SND;
        end else if (addr == A_SND_STAT || addr == A_PAD1) begin
            wr_tgt = TGT_SND;
        end else if (addr == A_DMA) begin
            wr_tgt = TGT_DMA;
        end else if (addr == A_PAD0) begin
            wr_tgt = TGT_PAD;
        end else begin
            wr_tgt = TGT_NONE;
        end
    end

    // Read-side map of the same window
    always_comb begin
        if (addr == A_SND_STAT) begin
            rd_tgt = TGT_SND;
        end else if (addr == A_PAD0 || addr == A_PAD1) begin
            rd_tgt = TGT_PAD;
        end else begin
            rd_tgt = TGT_NONE;
        end
    end

    // Priority: no strobe, cartridge, RAM mirror, video mirror, I/O window
    always_comb begin
        xact.wr = wr;
        xact.rd = rd & ~wr;
        if (!(rd || wr)) begin
            xact.tgt = TGT_NONE;
        end else if (claim) begin
            xact.tgt = TGT_CART;
        end else if (addr <= A_RAM_HI) begin
            xact.tgt = TGT_RAM;
        end else if (addr <= A_VID_HI) begin
            xact.tgt = TGT_VID;
        end else if (wr) begin
            xact.tgt = wr_tgt;
        end else begin
            xact.tgt = rd_tgt;
        end
    end

endmodule

// File: rtl/busdec_select.sv
module busdec_select
    import cpu_bus_pkg::*;
#(
    parameter int RAM_AW = 11,
    parameter int VID_AW = 3,
    parameter int SND_AW = 5
) (
    input  tgt_e              tgt,
    input  logic [RAM_AW-1:0] addr_lo,
    output logic              ram_sel,
    output logic              vid_sel,
    output logic              snd_sel,
    output logic              pad_sel,
    output logic              pad_port,
    output logic [RAM_AW-1:0] ram_off,
    output logic [VID_AW-1:0] vid_off,
    output logic [SND_AW-1:0] snd_off
);

    localparam int NSEL = 4;

    function automatic tgt_e sel_code(input int idx);
        case (idx)
            0:       sel_code = TGT_RAM;
            1:       sel_code = TGT_VID;
            2:       sel_code = TGT_SND;
            default: sel_code = TGT_PAD;
        endcase
    endfunction

    logic [NSEL-1:0] sel_vec;

    for (genvar g = 0; g < NSEL; g++) begin : g_sel
        assign sel_vec[g] = (tgt == sel_code(g));
    end

    assign ram_sel  = sel_vec[0];
    assign vid_sel  = sel_vec[1];
    assign snd_sel  = sel_vec[2];
    assign pad_sel  = sel_vec[3];

    // Mirroring: each device sees only its low address bits
    assign ram_off  = addr_lo;
    assign vid_off  = addr_lo[VID_AW-1:0];
    assign snd_off  = addr_lo[SND_AW-1:0];
    assign pad_port = addr_lo[0];

endmodule

// File: rtl/busdec_phase.sv
module busdec_phase
    import cpu_bus_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tgt_e              tgt,
    input  logic              rd,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              dma_start,
    output logic [DATA_W-1:0] dma_page
);

    phase_e state;
    phase_e state_nx;

    // Next-state selection
    always_comb begin
        if (tgt == TGT_DMA) begin
            state_nx = ST_DMA;
        end else if (wr) begin
            state_nx = ST_WRITE;
        end else if (rd) begin
            state_nx = ST_READ;
        end else begin
            state_nx = ST_IDLE;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Outputs from the state
    always_comb begin
        unique case (state)
            ST_IDLE:  dma_start = 1'b0;
            ST_READ:  dma_start = 1'b0;
            ST_WRITE: dma_start = 1'b0;
            ST_DMA:   dma_start = 1'b1;
        endcase
    end

    // Page latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_page <= '0;
        end else if (tgt == TGT_DMA) begin
            dma_page <= wdata;
        end
    end

    // R5
    dma_page_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_start && $past(rst_n)) |-> $stable(dma_page));

endmodule

// File: rtl/busdec_rdsteer.sv
module busdec_rdsteer
    import cpu_bus_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tgt_e              tgt,
    input  logic              rd,
    input  logic [DATA_W-1:0] ram_rdata,
    input  logic [DATA_W-1:0] vid_rdata,
    input  logic [DATA_W-1:0] snd_rdata,
    input  logic [DATA_W-1:0] pad_rdata,
    input  logic [DATA_W-1:0] cart_rdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mux_q;

    always_comb begin
        unique case (tgt)
            TGT_RAM:  mux_q = ram_rdata;
            TGT_VID:  mux_q = vid_rdata;
            TGT_SND:  mux_q = snd_rdata;
            TGT_PAD:  mux_q = pad_rdata;
            TGT_CART: mux_q = cart_rdata;
            default:  mux_q = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd) begin
            rdata <= mux_q;
        end
    end

    // R7
    open_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd && tgt == TGT_NONE && rst_n) |-> (rdata == '0));

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rd) && $past(rst_n)) |-> $stable(rdata));

endmodule

// File: rtl/cpu_bus_decoder.sv
module cpu_bus_decoder
    import cpu_bus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int RAM_AW = 11,
    parameter int VID_AW = 3,
    parameter int SND_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              cart_claim,
    input  logic [DATA_W-1:0] cart_rdata,
    output logic              ram_sel,
    output logic [RAM_AW-1:0] ram_off,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              vid_sel,
    output logic [VID_AW-1:0] vid_off,
    input  logic [DATA_W-1:0] vid_rdata,
    output logic              snd_sel,
    output logic [SND_AW-1:0] snd_off,
    input  logic [DATA_W-1:0] snd_rdata,
    output logic              pad_sel,
    output logic              pad_port,
    input  logic [DATA_W-1:0] pad_rdata,
    output logic              dma_start,
    output logic [DATA_W-1:0] dma_page
);

    localparam logic [ADDR_W-1:0] A_DMA    = ADDR_W'(MAP_DMA);
    localparam logic [ADDR_W-1:0] A_RAM_HI = ADDR_W'(MAP_RAM_HI);

    xact_t xact;

    busdec_classify #(.ADDR_W(ADDR_W)) u_classify (
        .addr  (cpu_addr),
        .rd    (cpu_rd),
        .wr    (cpu_wr),
        .claim (cart_claim),
        .xact  (xact)
    );

    busdec_select #(
        .RAM_AW (RAM_AW),
        .VID_AW (VID_AW),
        .SND_AW (SND_AW)
    ) u_select (
        .tgt      (xact.tgt),
        .addr_lo  (cpu_addr[RAM_AW-1:0]),
        .ram_sel  (ram_sel),
        .vid_sel  (vid_sel),
        .snd_sel  (snd_sel),
        .pad_sel  (pad_sel),
        .pad_port (pad_port),
        .ram_off  (ram_off),
        .vid_off  (vid_off),
        .snd_off  (snd_off)
    );

    busdec_phase #(.DATA_W(DATA_W)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .tgt       (xact.tgt),
        .rd        (xact.rd),
        .wr        (xact.wr),
        .wdata     (cpu_wdata),
        .dma_start (dma_start),
        .dma_page  (dma_page)
    );

    busdec_rdsteer #(.DATA_W(DATA_W)) u_rdsteer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tgt        (xact.tgt),
        .rd         (xact.rd),
        .ram_rdata  (ram_rdata),
        .vid_rdata  (vid_rdata),
        .snd_rdata  (snd_rdata),
        .pad_rdata  (pad_rdata),
        .cart_rdata (cart_rdata),
        .rdata      (cpu_rdata)
    );

    // R8
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_sel, vid_sel, snd_sel, pad_sel}));

    // R8
    sel_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_rd || cpu_wr) |-> !(ram_sel || vid_sel || snd_sel || pad_sel));

    // R1
    cart_veto_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cart_claim && (cpu_rd || cpu_wr)) |-> !(ram_sel || vid_sel || snd_sel || pad_sel));

    // R2
    ram_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_sel |-> (cpu_addr <= A_RAM_HI));

    // R5
    dma_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_start |-> $past(cpu_wr && !cart_claim && cpu_addr == A_DMA));

    // R5
    dma_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_start |-> (dma_page == $past(cpu_wdata)));

endmodule

// File: tb/tb_cpu_bus_decoder.sv
`timescale 1ns/1ps
module tb_cpu_bus_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        cart_claim;
    logic [7:0]  cart_rdata;
    logic        ram_sel, vid_sel, snd_sel, pad_sel, pad_port, dma_start;
    logic [10:0] ram_off;
    logic [2:0]  vid_off;
    logic [4:0]  snd_off;
    logic [7:0]  ram_rdata, vid_rdata, snd_rdata, pad_rdata, dma_page;
    logic        cart_force = 1'b0;

    logic [7:0]  ram_m [2048];
    logic [7:0]  vid_m [8];
    logic [7:0]  snd_m [32];

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    logic [7:0] exp_rdata = 8'h00;
    logic       exp_dma = 1'b0;
    logic [7:0] exp_page = 8'h00;

    always #4 clk = ~clk;

    // Bench cartridge: claims the upper space and one slice of the RAM mirror
    function automatic bit claim_fn(input logic [15:0] a);
        return (a >= 16'h4020) || (a[15:8] == 8'h1F);
    endfunction

    assign cart_claim = cart_force | claim_fn(cpu_addr);
    assign cart_rdata = cpu_addr[7:0] ^ 8'hA5;
    assign ram_rdata  = ram_m[ram_off];
    assign vid_rdata  = vid_m[vid_off];
    assign snd_rdata  = snd_m[snd_off];
    assign pad_rdata  = pad_port ? 8'h81 : 8'h42;

    cpu_bus_decoder dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cart_claim(cart_claim), .cart_rdata(cart_rdata),
        .ram_sel(ram_sel), .ram_off(ram_off), .ram_rdata(ram_rdata),
        .vid_sel(vid_sel), .vid_off(vid_off), .vid_rdata(vid_rdata),
        .snd_sel(snd_sel), .snd_off(snd_off), .snd_rdata(snd_rdata),
        .pad_sel(pad_sel), .pad_port(pad_port), .pad_rdata(pad_rdata),
        .dma_start(dma_start), .dma_page(dma_page)
    );

    // Reference map: 0 none, 1 RAM, 2 video, 3 audio, 4 pads, 5 DMA, 6 cartridge
    function automatic int ref_target(input logic [15:0] a, input bit r, input bit w, input bit c);
        int ia;
        ia = int'(a);
        if (!r && !w) return 0;
        if (c) return 6;
        if (ia < 8192) return 1;
        if (ia < 16384) return 2;
        if (w) begin
            if (ia >= 16'h4000 && ia <= 16'h4013) return 3;
            if (ia == 16'h4015 || ia == 16'h4017) return 3;
            if (ia == 16'h4014) return 5;
            if (ia == 16'h4016) return 4;
            return 0;
        end
        if (ia == 16'h4015) return 3;
        if (ia == 16'h4016 || ia == 16'h4017) return 4;
        return 0;
    endfunction

    function automatic string tag_of(input int t, input bit r, input bit w);
        if (r && w) return "R10";
        case (t)
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R6";
            5: return "R5";
            6: return "R1";
            default: return "R7";
        endcase
    endfunction

    task automatic step(input logic [15:0] a, input bit r, input bit w, input logic [7:0] d);
        int t;
        bit bad;
        string tg;
        @(negedge clk);
        if (finished) return;
        bad = 0;
        // registered outputs from the previous edge
        if (cpu_rdata !== exp_rdata) begin
            $display("FAIL R9 cpu_rdata act=%h exp=%h", cpu_rdata, exp_rdata); bad = 1;
        end
        if (dma_start !== exp_dma) begin
            $display("FAIL R5 dma_start act=%b exp=%b", dma_start, exp_dma); bad = 1;
        end
        if (dma_page !== exp_page) begin
            $display("FAIL R5 dma_page act=%h exp=%h", dma_page, exp_page); bad = 1;
        end
        cpu_addr = a; cpu_rd = r; cpu_wr = w; cpu_wdata = d;
        #1;
        t  = ref_target(a, r, w, cart_force | claim_fn(a));
        tg = tag_of(t, r, w);
        if (ram_sel !== (t == 1)) begin
            $display("FAIL %s ram_sel addr=%h act=%b exp=%b", tg, a, ram_sel, t == 1); bad = 1;
        end
        if (vid_sel !== (t == 2)) begin
            $display("FAIL %s vid_sel addr=%h act=%b exp=%b", tg, a, vid_sel, t == 2); bad = 1;
        end
        if (snd_sel !== (t == 3)) begin
            $display("FAIL %s snd_sel addr=%h act=%b exp=%b", tg, a, snd_sel, t == 3); bad = 1;
        end
        if (pad_sel !== (t == 4)) begin
            $display("FAIL %s pad_sel addr=%h act=%b exp=%b", tg, a, pad_sel, t == 4); bad = 1;
        end
        if ($countones({ram_sel, vid_sel, snd_sel, pad_sel}) > 1) begin
            $display("FAIL R8 selects addr=%h act=%b exp=onehot0", a, {ram_sel, vid_sel, snd_sel, pad_sel}); bad = 1;
        end
        if (t == 1 && ram_off !== a[10:0]) begin
            $display("FAIL R2 ram_off act=%h exp=%h", ram_off, a[10:0]); bad = 1;
        end
        if (t == 2 && vid_off !== a[2:0]) begin
            $display("FAIL R3 vid_off act=%h exp=%h", vid_off, a[2:0]); bad = 1;
        end
        if (t == 3 && snd_off !== a[4:0]) begin
            $display("FAIL R4 snd_off act=%h exp=%h", snd_off, a[4:0]); bad = 1;
        end
        if (t == 4 && pad_port !== a[0]) begin
            $display("FAIL R6 pad_port act=%b exp=%b", pad_port, a[0]); bad = 1;
        end
        // expectations for the coming edge
        if (r && !w) begin
            case (t)
                1: exp_rdata = ram_m[a[10:0]];
                2: exp_rdata = vid_m[a[2:0]];
                3: exp_rdata = snd_m[a[4:0]];
                4: exp_rdata = a[0] ? 8'h81 : 8'h42;
                6: exp_rdata = a[7:0] ^ 8'hA5;
                default: exp_rdata = 8'h00;
            endcase
        end
        if (w) begin
            case (t)
                1: ram_m[a[10:0]] = d;
                2: vid_m[a[2:0]] = d;
                3: snd_m[a[4:0]] = d;
                default: ;
            endcase
        end
        exp_dma = (t == 5);
        if (t == 5) exp_page = d;
        vectors++;
        if (bad) miscompares++;
    endtask

    initial begin
        for (int i = 0; i < 2048; i++) ram_m[i] = 8'((i * 7) + 3);
        for (int i = 0; i < 8; i++)    vid_m[i] = 8'(8'h30 + i);
        for (int i = 0; i < 32; i++)   snd_m[i] = 8'(8'hC0 + i);

        // R11: reset values
        repeat (3) @(posedge clk);
        @(negedge clk);
        vectors++;
        if (cpu_rdata !== 8'h00 || dma_start !== 1'b0 || dma_page !== 8'h00) begin
            $display("FAIL R11 reset act=%h/%b/%h exp=00/0/00", cpu_rdata, dma_start, dma_page);
            miscompares++;
        end
        rst_n = 1'b1;

        // Full read sweep: R1 R2 R3 R4 R6 R7 R8 R9
        for (int i = 0; i < 65536; i++) step(16'(i), 1'b1, 1'b0, 8'h00);
        // Full write sweep, DMA port included: R5 R8
        for (int i = 0; i < 65536; i++) step(16'(i), 1'b0, 1'b1, 8'(i ^ (i >> 8)));

        // R2 mirror: write one alias, read others
        step(16'h0805, 1'b0, 1'b1, 8'h3C);
        step(16'h1005, 1'b1, 1'b0, 8'h00);
        step(16'h0005, 1'b1, 1'b0, 8'h00);
        // R3 mirror
        step(16'h2009, 1'b0, 1'b1, 8'h5A);
        step(16'h3FF1, 1'b1, 1'b0, 8'h00);
        // R4 audio status and R9 hold across idle and write
        step(16'h4015, 1'b1, 1'b0, 8'h00);
        step(16'h0000, 1'b0, 1'b0, 8'h00);
        step(16'h4003, 1'b0, 1'b1, 8'h11);
        step(16'h0000, 1'b0, 1'b0, 8'h00);
        // R6 both ports and the latch write
        step(16'h4016, 1'b1, 1'b0, 8'h00);
        step(16'h4017, 1'b1, 1'b0, 8'h00);
        step(16'h4016, 1'b0, 1'b1, 8'h01);
        // R5 DMA pulse, back to back, then idle
        step(16'h4014, 1'b0, 1'b1, 8'h02);
        step(16'h4014, 1'b0, 1'b1, 8'h07);
        step(16'h0000, 1'b0, 1'b0, 8'h00);
        step(16'h0000, 1'b0, 1'b0, 8'h00);
        // R1 forced claim vetoes DMA and RAM
        cart_force = 1'b1;
        step(16'h4014, 1'b0, 1'b1, 8'h99);
        step(16'h0010, 1'b1, 1'b0, 8'h00);
        step(16'h0000, 1'b0, 1'b0, 8'h00);
        cart_force = 1'b0;
        // R10 both strobes act as a write
        step(16'h0010, 1'b1, 1'b1, 8'h77);
        step(16'h0010, 1'b1, 1'b0, 8'h00);
        // R7 unmapped reads
        step(16'h4000, 1'b1, 1'b0, 8'h00);
        step(16'h401F, 1'b1, 1'b0, 8'h00);
        step(16'h0000, 1'b0, 1'b0, 8'h00);

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            miscompares++;
            $display("FAIL watchdog act=running exp=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule